// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block lets a host processor read and write the control registers of an external AC97 codec. The host programs a command through a small 32-bit register bus. The block then places the command into the command address slot, and for writes also the command data slot, of the next frame the link layer offers. The codec answers through its status address and status data slots. The block captures these answers and raises sticky per-slot flags that the host polls and clears.

The link side is abstracted to one frame strobe per frame, two tagged outgoing slots and two tagged incoming slots, plus a codec-ready input. Serial bit shifting is left to a neighbouring block. The block also drives the codec's reset line and a sync pulse for cold and warm resets. A command is only issued when the codec reports ready, the link is started and the host has armed command transmission. Until all three hold, the command waits.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: After reset, no slot is offered, codec_rst_n is 1, sync_pulse is 0, and the control, transmit status and receive status registers read 0 while codec_ready is 0.
- R2: Writing offset 0x20 with bit 19 clear queues a write command. One cycle after the next accepted frame strobe, tx_slot1 = {0, index(bits 18:12), 12'b0} and tx_slot2 = {data from offset 0x24 bits 19:4, 4'b0} are both valid for one cycle. Transmit status (0x54) bits 31 and 30 are then set.
- R3: Writing offset 0x20 with bit 19 set queues a read command. Only tx_slot1 is valid, with bit 19 set, and only transmit status bit 31 is set.
- R4: A queued command is not issued while codec_ready is 0, control (0x08) bit 5 is clear, or audio-control (0x60) bit 26 is clear. It stays pending and is issued at the first frame strobe at which all three hold.
- R5: Each write to offset 0x20 issues exactly one command. Later frame strobes offer no slot.
- R6: Status flags stay set until the host writes their register with that bit at 0. Writing the bit as 1 leaves the flag unchanged.
- R7: If hardware sets a flag in the same cycle as a host write that clears it, the flag ends up set.
- R8: A valid rx_slot1 sets receive status (0x5C) bit 22 and loads its bits 18:12 into bits 18:12 of offset 0x20. A valid rx_slot2 sets bit 21 and loads its bits 19:4 into bits 19:4 of offset 0x24.
- R9: While control bit 11 is set, codec_rst_n is 0. It returns to 1 once the bit is cleared.
- R10: While control bit 10 is set, sync_pulse is 1. It returns to 0 once the bit is cleared.
- R11: Control bit 15 reads back the current codec_ready input. It cannot be written.
- R12: Audio-control keeps only bits 30, 29, 26, 24, 23, 22 and 21. All other bits read 0.
- R13: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| frame_valid | input | 1 | One-cycle strobe: a frame can take command slots |
| codec_ready | input | 1 | Codec reports ready |
| tx_slot1_vld | output | 1 | Command address slot valid |
| tx_slot1 | output | 20 | Command address slot content |
| tx_slot2_vld | output | 1 | Command data slot valid |
| tx_slot2 | output | 20 | Command data slot content |
| rx_slot1_vld | input | 1 | Status address slot received |
| rx_slot1 | input | 20 | Status address slot content |
| rx_slot2_vld | input | 1 | Status data slot received |
| rx_slot2 | input | 20 | Status data slot content |
| codec_rst_n | output | 1 | Codec cold reset, active low |
| sync_pulse | output | 1 | Warm reset sync drive |

## Verification
The assertions watch every cycle for properties that hold regardless of the stimulus. A slot is offered only after a frame strobe with all three gates open. A read never offers a data slot, and a data slot never appears without an address slot. Flags persist unless cleared, and a set beats a simultaneous clear. The reset output follows the cold reset bit. The bench scenarios cover what needs a known history: the exact slot contents, a command waiting across gated frames, the one-command-per-write rule, the capture of codec answers into the shared fields, and the masked register readback.

// File: rtl/ac97c_pkg.sv
package ac97c_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_CADDR = 8'h20;
  localparam logic [7:0] OFS_CDATA = 8'h24;
  localparam logic [7:0] OFS_TSTAT = 8'h54;
  localparam logic [7:0] OFS_RSTAT = 8'h5C;
  localparam logic [7:0] OFS_AUDIO = 8'h60;

  localparam int CTRL_READY_BIT = 15;
  localparam int CTRL_COLD_BIT  = 11;
  localparam int CTRL_WARM_BIT  = 10;
  localparam int CTRL_START_BIT = 5;

  localparam int TST_ADDR_BIT = 31;
  localparam int TST_DATA_BIT = 30;
  localparam int RST_ADDR_BIT = 22;
  localparam int RST_DATA_BIT = 21;

  localparam int AUD_ARM_BIT = 26;
  localparam logic [31:0] AUD_KEEP_MASK = 32'h65E0_0000;
endpackage

// File: rtl/ac97c_sticky.sv
module ac97c_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else if (set[i])
        flags[i] <= 1'b1;
      else if (clr_wr && !wbits[i])
        flags[i] <= 1'b0;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      ($past(flags[i]) && !$past(clr_wr)) |-> flags[i]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      $past(set[i]) |-> flags[i]); // R7
  end
endmodule

// File: rtl/ac97c_host_regs.sv
module ac97c_host_regs
  import ac97c_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 7,
  parameter int DAT_W  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              codec_ready,
  input  logic              rx1_vld,
  input  logic [SLOT_W-1:0] rx1,
  input  logic              rx2_vld,
  input  logic [SLOT_W-1:0] rx2,
  input  logic [1:0]        tx_flags,
  input  logic [1:0]        rx_flags,
  output logic              ctl_start,
  output logic              ctl_cold,
  output logic              ctl_warm,
  output logic              arm_en,
  output logic              cmd_stb,
  output logic              cmd_rd,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [DAT_W-1:0]  cmd_dat,
  output logic              tst_wr,
  output logic [1:0]        tst_wbits,
  output logic              rst_wr,
  output logic [1:0]        rst_wbits
);
  localparam int RD_BIT  = SLOT_W - 1;
  localparam int IDX_LSB = RD_BIT - IDX_W;
  localparam int DAT_LSB = SLOT_W - DAT_W;

  logic [7:0]       ofs;
  logic             wr_en;
  logic [IDX_W-1:0] fld_idx;
  logic             fld_rd;
  logic [DAT_W-1:0] fld_dat;
  logic [31:0]      aud_q;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign ofs   = 8'(bus_addr);
  assign wr_en = bus_sel && bus_wr;

  assign cmd_stb   = wr_en && (ofs == OFS_CADDR);
  assign cmd_rd    = bus_wdata[RD_BIT];
  assign cmd_idx   = bus_wdata[IDX_LSB +: IDX_W];
  assign cmd_dat   = fld_dat;
  assign tst_wr    = wr_en && (ofs == OFS_TSTAT);
  assign tst_wbits = {bus_wdata[TST_ADDR_BIT], bus_wdata[TST_DATA_BIT]};
  assign rst_wr    = wr_en && (ofs == OFS_RSTAT);
  assign rst_wbits = {bus_wdata[RST_ADDR_BIT], bus_wdata[RST_DATA_BIT]};
  assign arm_en    = aud_q[AUD_ARM_BIT];
  assign unused_bits = ^{bus_wdata, rx1, rx2};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_start <= 1'b0;
      ctl_cold  <= 1'b0;
      ctl_warm  <= 1'b0;
      aud_q     <= '0;
    end else if (wr_en) begin
      if (ofs == OFS_CTRL) begin
        ctl_start <= bus_wdata[CTRL_START_BIT];
        ctl_cold  <= bus_wdata[CTRL_COLD_BIT];
        ctl_warm  <= bus_wdata[CTRL_WARM_BIT];
      end
      if (ofs == OFS_AUDIO)
        aud_q <= bus_wdata & AUD_KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_idx <= '0;
      fld_rd  <= 1'b0;
    end else if (cmd_stb) begin
      fld_idx <= cmd_idx;
      fld_rd  <= cmd_rd;
    end else if (rx1_vld) begin
      fld_idx <= rx1[IDX_LSB +: IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fld_dat <= '0;
    else if (wr_en && ofs == OFS_CDATA)
      fld_dat <= bus_wdata[DAT_LSB +: DAT_W];
    else if (rx2_vld)
      fld_dat <= rx2[DAT_LSB +: DAT_W];
  end

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_CTRL: begin
        rd_mux[CTRL_READY_BIT] = codec_ready;
        rd_mux[CTRL_COLD_BIT]  = ctl_cold;
        rd_mux[CTRL_WARM_BIT]  = ctl_warm;
        rd_mux[CTRL_START_BIT] = ctl_start;
      end
      OFS_CADDR: begin
        rd_mux[RD_BIT]               = fld_rd;
        rd_mux[IDX_LSB +: IDX_W]     = fld_idx;
      end
      OFS_CDATA: rd_mux[DAT_LSB +: DAT_W] = fld_dat;
      OFS_TSTAT: begin
        rd_mux[TST_ADDR_BIT] = tx_flags[1];
        rd_mux[TST_DATA_BIT] = tx_flags[0];
      end
      OFS_RSTAT: begin
        rd_mux[RST_ADDR_BIT] = rx_flags[1];
        rd_mux[RST_DATA_BIT] = rx_flags[0];
      end
      OFS_AUDIO: rd_mux = aud_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_sel && !bus_wr)
      bus_rdata <= rd_mux;
  end

  AST_AUDIO_MASKED: assert property (@(posedge clk) disable iff (rst)
    (aud_q & ~AUD_KEEP_MASK) == 32'h0); // R12
endmodule

// File: rtl/ac97c_cmd_engine.sv
module ac97c_cmd_engine #(
  parameter int IDX_W  = 7,
  parameter int DAT_W  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              cmd_rd,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DAT_W-1:0]  cmd_dat,
  input  logic              frame_valid,
  input  logic              codec_ready,
  input  logic              link_start,
  input  logic              arm_en,
  output logic              tx1_vld,
  output logic [SLOT_W-1:0] tx1,
  output logic              tx2_vld,
  output logic [SLOT_W-1:0] tx2,
  output logic              addr_done_set,
  output logic              data_done_set
);
  localparam int RD_BIT  = SLOT_W - 1;
  localparam int IDX_LSB = RD_BIT - IDX_W;
  localparam int DAT_LSB = SLOT_W - DAT_W;

  logic             pending;
  logic             q_rd;
  logic [IDX_W-1:0] q_idx;
  logic [DAT_W-1:0] q_dat;
  logic             issue;

  assign issue         = pending && frame_valid && codec_ready && link_start && arm_en;
  assign addr_done_set = issue;
  assign data_done_set = issue && !q_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      q_rd    <= 1'b0;
      q_idx   <= '0;
      q_dat   <= '0;
    end else if (cmd_stb) begin
      pending <= 1'b1;
      q_rd    <= cmd_rd;
      q_idx   <= cmd_idx;
      q_dat   <= cmd_dat;
    end else if (issue) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx1_vld <= 1'b0;
      tx1     <= '0;
      tx2_vld <= 1'b0;
      tx2     <= '0;
    end else begin
      tx1_vld <= issue;
      tx2_vld <= issue && !q_rd;
      tx1     <= '0;
      tx2     <= '0;
      if (issue) begin
        tx1[RD_BIT]              <= q_rd;
        tx1[IDX_LSB +: IDX_W]    <= q_idx;
        if (!q_rd)
          tx2[DAT_LSB +: DAT_W]  <= q_dat;
      end
    end
  end

  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    tx1_vld |-> $past(frame_valid && codec_ready && link_start && arm_en)); // R4
  AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (tx1_vld && tx1[RD_BIT]) |-> !tx2_vld); // R3
  AST_DATA_PAIRED: assert property (@(posedge clk) disable iff (rst)
    tx2_vld |-> tx1_vld); // R2
endmodule

// File: rtl/ac97c_reset_ctl.sv
module ac97c_reset_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cold_req,
  input  logic warm_req,
  output logic codec_rst_n,
  output logic sync_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      codec_rst_n <= 1'b1;
      sync_pulse  <= 1'b0;
    end else begin
      codec_rst_n <= !cold_req;
      sync_pulse  <= warm_req;
    end
  end

  AST_COLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    codec_rst_n == !$past(cold_req)); // R9
  AST_WARM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sync_pulse == $past(warm_req)); // R10
endmodule

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 7,
  parameter int DAT_W  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_valid,
  input  logic              codec_ready,
  output logic              tx_slot1_vld,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic              tx_slot2_vld,
  output logic [SLOT_W-1:0] tx_slot2,
  input  logic              rx_slot1_vld,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic              rx_slot2_vld,
  input  logic [SLOT_W-1:0] rx_slot2,
  output logic              codec_rst_n,
  output logic              sync_pulse
);
  logic             ctl_start, ctl_cold, ctl_warm, arm_en;
  logic             cmd_stb, cmd_rd;
  logic [IDX_W-1:0] cmd_idx;
  logic [DAT_W-1:0] cmd_dat;
  logic             tst_wr, rst_wr;
  logic [1:0]       tst_wbits, rst_wbits;
  logic [1:0]       tx_flags, rx_flags;
  logic             addr_done_set, data_done_set;

  ac97c_host_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DAT_W(DAT_W), .SLOT_W(SLOT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .codec_ready(codec_ready),
    .rx1_vld(rx_slot1_vld), .rx1(rx_slot1),
    .rx2_vld(rx_slot2_vld), .rx2(rx_slot2),
    .tx_flags(tx_flags), .rx_flags(rx_flags),
    .ctl_start(ctl_start), .ctl_cold(ctl_cold), .ctl_warm(ctl_warm),
    .arm_en(arm_en),
    .cmd_stb(cmd_stb), .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_dat(cmd_dat),
    .tst_wr(tst_wr), .tst_wbits(tst_wbits),
    .rst_wr(rst_wr), .rst_wbits(rst_wbits)
  );

  ac97c_cmd_engine #(
    .IDX_W(IDX_W), .DAT_W(DAT_W), .SLOT_W(SLOT_W)
  ) u_engine (
    .clk(clk), .rst(rst),
    .cmd_stb(cmd_stb), .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_dat(cmd_dat),
    .frame_valid(frame_valid), .codec_ready(codec_ready),
    .link_start(ctl_start), .arm_en(arm_en),
    .tx1_vld(tx_slot1_vld), .tx1(tx_slot1),
    .tx2_vld(tx_slot2_vld), .tx2(tx_slot2),
    .addr_done_set(addr_done_set), .data_done_set(data_done_set)
  );

  ac97c_sticky #(.N(2)) u_tx_flags (
    .clk(clk), .rst(rst),
    .set({addr_done_set, data_done_set}),
    .clr_wr(tst_wr), .wbits(tst_wbits), .flags(tx_flags)
  );

  ac97c_sticky #(.N(2)) u_rx_flags (
    .clk(clk), .rst(rst),
    .set({rx_slot1_vld, rx_slot2_vld}),
    .clr_wr(rst_wr), .wbits(rst_wbits), .flags(rx_flags)
  );

  ac97c_reset_ctl u_rstctl (
    .clk(clk), .rst(rst),
    .cold_req(ctl_cold), .warm_req(ctl_warm),
    .codec_rst_n(codec_rst_n), .sync_pulse(sync_pulse)
  );
endmodule

// File: tb/ac97_cmd_ctrl_bench.sv
module ac97_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_valid = 1'b0, codec_ready = 1'b0;
  logic        tx_slot1_vld, tx_slot2_vld;
  logic [19:0] tx_slot1, tx_slot2;
  logic        rx_slot1_vld = 1'b0, rx_slot2_vld = 1'b0;
  logic [19:0] rx_slot1 = '0, rx_slot2 = '0;
  logic        codec_rst_n, sync_pulse;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ac97_cmd_ctrl u_ac97_cmd_ctrl (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_valid(frame_valid), .codec_ready(codec_ready),
    .tx_slot1_vld(tx_slot1_vld), .tx_slot1(tx_slot1),
    .tx_slot2_vld(tx_slot2_vld), .tx_slot2(tx_slot2),
    .rx_slot1_vld(rx_slot1_vld), .rx_slot1(rx_slot1),
    .rx_slot2_vld(rx_slot2_vld), .rx_slot2(rx_slot2),
    .codec_rst_n(codec_rst_n), .sync_pulse(sync_pulse)
  );

  function automatic logic [19:0] exp_s1(logic rd, logic [6:0] idx);
    return {rd, idx, 12'h000};
  endfunction
  function automatic logic [19:0] exp_s2(logic [15:0] d);
    return {d, 4'h0};
  endfunction
  function automatic logic [31:0] exp_tst(logic rd);
    return rd ? 32'h8000_0000 : 32'hC000_0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic frame(output logic v1, output logic [19:0] s1,
                       output logic v2, output logic [19:0] s2);
    @(negedge clk);
    frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
    v1 = tx_slot1_vld; s1 = tx_slot1; v2 = tx_slot2_vld; s2 = tx_slot2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic v1, v2;
    logic [19:0] s1, s2;
    process::self().srandom(32'd1234);

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 tx1_vld", {31'b0, tx_slot1_vld}, 0);
    check("R1 rst_n", {31'b0, codec_rst_n}, 1);
    check("R1 sync", {31'b0, sync_pulse}, 0);
    rd(8'h08, r); check("R1 ctrl", r, 0);
    rd(8'h54, r); check("R1 tstat", r, 0);
    rd(8'h5C, r); check("R1 rstat", r, 0);

    // R4 gating: command waits while any gate is closed
    wr(8'h24, 32'h000A_BCD0);
    wr(8'h20, exp_s1(0, 7'h2C));
    frame(v1, s1, v2, s2); check("R4 no codec_ready", {31'b0, v1}, 0);
    codec_ready = 1;
    frame(v1, s1, v2, s2); check("R4 no start", {31'b0, v1}, 0);
    wr(8'h08, 32'h0000_0020);
    frame(v1, s1, v2, s2); check("R4 not armed", {31'b0, v1}, 0);
    rd(8'h54, r); check("R4 no flags while pending", r, 0);
    wr(8'h60, 32'h0400_0000);
    frame(v1, s1, v2, s2);
    check("R4 issued once gates open", {31'b0, v1}, 1);
    check("R2 slot1", {12'b0, s1}, {12'b0, exp_s1(0, 7'h2C)});
    check("R2 slot2 vld", {31'b0, v2}, 1);
    check("R2 slot2", {12'b0, s2}, {12'b0, exp_s2(16'hABCD)});
    rd(8'h54, r); check("R2 tstat", r, exp_tst(0));

    // R6 clear by writing 0, keep by writing 1
    wr(8'h54, 32'h4000_0000);
    rd(8'h54, r); check("R6 partial clear", r, 32'h4000_0000);
    wr(8'h54, 32'h0);
    rd(8'h54, r); check("R6 full clear", r, 0);

    // R5 no repeat
    frame(v1, s1, v2, s2); check("R5 no second issue", {31'b0, v1}, 0);

    // R3 read command
    wr(8'h20, 32'h0008_0000 | {12'b0, exp_s1(0, 7'h7E)});
    frame(v1, s1, v2, s2);
    check("R3 slot1", {11'b0, v1, s1}, {11'b0, 1'b1, exp_s1(1, 7'h7E)});
    check("R3 no slot2", {31'b0, v2}, 0);
    rd(8'h54, r); check("R3 tstat", r, exp_tst(1));
    wr(8'h54, 32'h0);

    // R7 set beats clear
    wr(8'h20, exp_s1(0, 7'h11));
    @(negedge clk);
    frame_valid = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h54; bus_wdata = 0;
    @(negedge clk);
    frame_valid = 0; bus_sel = 0; bus_wr = 0;
    check("R7 issued", {31'b0, tx_slot1_vld}, 1);
    rd(8'h54, r); check("R7 set wins", r, exp_tst(0));
    wr(8'h54, 32'h0);

    // R8 receive slots
    @(negedge clk);
    rx_slot1_vld = 1; rx_slot1 = exp_s1(0, 7'h55);
    @(negedge clk);
    rx_slot1_vld = 0; rx_slot2_vld = 1; rx_slot2 = exp_s2(16'h1357);
    @(negedge clk);
    rx_slot2_vld = 0;
    rd(8'h5C, r); check("R8 rstat", r, 32'h0060_0000);
    rd(8'h20, r); check("R8 index field", r & 32'h0007_F000, 32'h0005_5000);
    rd(8'h24, r); check("R8 data field", r, 32'h0001_3570);
    wr(8'h5C, 32'h0);
    rd(8'h5C, r); check("R8 rstat cleared", r, 0);

    // R9 cold reset, R10 warm reset
    wr(8'h08, 32'h0000_0820);
    @(negedge clk);
    check("R9 rst_n low", {31'b0, codec_rst_n}, 0);
    wr(8'h08, 32'h0000_0420);
    @(negedge clk);
    check("R9 rst_n released", {31'b0, codec_rst_n}, 1);
    check("R10 sync high", {31'b0, sync_pulse}, 1);
    wr(8'h08, 32'h0000_8020);
    @(negedge clk);
    check("R10 sync low", {31'b0, sync_pulse}, 0);

    // R11 codec ready readback (write of bit 15 ignored)
    codec_ready = 0;
    rd(8'h08, r); check("R11 ready low", r, 32'h0000_0020);
    codec_ready = 1;
    rd(8'h08, r); check("R11 ready high", r, 32'h0000_8020);

    // R12 audio mask, R13 unmapped
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, r); check("R12 audio mask", r, 32'h65E0_0000);
    rd(8'h10, r); check("R13 unmapped", r, 0);
    wr(8'h60, 32'h0400_0000);

    // R2/R3 random commands
    for (int i = 0; i < 40; i++) begin
      logic        rr = 1'($urandom);
      logic [6:0]  ix = 7'($urandom);
      logic [15:0] dv = 16'($urandom);
      wr(8'h24, {12'b0, exp_s2(dv)});
      wr(8'h20, {12'b0, exp_s1(rr, ix)});
      frame(v1, s1, v2, s2);
      check(rr ? "R3 rand slot1" : "R2 rand slot1", {11'b0, v1, s1}, {11'b0, 1'b1, exp_s1(rr, ix)});
      check(rr ? "R3 rand slot2" : "R2 rand slot2", {11'b0, v2, s2}, rr ? 32'h0 : {11'b0, 1'b1, exp_s2(dv)});
      rd(8'h54, r); check("R2 rand tstat", r, exp_tst(rr));
      wr(8'h54, 32'h0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule